// File: doc/BRIEF.md
# Byte-Lane Static RAM Core

This block is a clocked, synthesizable model of a word-organised static memory with a 16-bit word split into two independently controlled byte lanes. Five active-low controls qualify every cycle: chip select, write strobe, output enable, low-lane select and high-lane select. An address and a write word complete the inputs. Real three-state pins are replaced by a per-lane drive flag that the surrounding logic uses to decide who owns each byte of a shared bus. A standby flag reports when the chip is not selected.

Each cycle, a decoder turns the controls into one of five operating states. A state register then holds that state and produces the outputs. Writes land in the array on the rising clock edge. Read data and the drive flags are registered, so they appear one cycle after the read conditions are presented. The array is never cleared, so contents are undefined until written.

The states are:
- `OP_STANDBY`: chip not selected.
- `OP_NOLANE`: selected, but neither lane is selected.
- `OP_WRITE`: selected, with the write strobe low.
- `OP_READ`: selected, write strobe high and output enable low.
- `OP_HOLD`: selected, write strobe high and output enable high.

The decoder resolves them in that priority order, from `OP_STANDBY` down to `OP_HOLD`. Any state can move to any other on the next edge, and reset forces `OP_STANDBY`. The address width is a parameter; 18 bits gives the full 262,144-word array.

Top module: `bytelane_sram`

## Requirements
- R1: With `chip_sel_n` high, the next cycle shows `lane_drive` = 2'b00, `rdata` = 0 and `standby` = 1, and no byte of the array is written.
- R2: With `chip_sel_n` low, `wr_n` low and at least one lane selected, the selected bytes are written at that edge whatever `out_en_n` is, and the next cycle shows `lane_drive` = 2'b00.
- R3: With `chip_sel_n` low, `wr_n` high and `out_en_n` low, the next cycle shows each selected lane's drive bit set and its stored byte on `rdata`.
- R4: Lane 0 is bits 7..0, is selected by `lane_lo_n` low and is flagged by `lane_drive[0]`. Lane 1 is bits 15..8, is selected by `lane_hi_n` low and is flagged by `lane_drive[1]`.
- R5: With the chip selected and both `lane_lo_n` and `lane_hi_n` high, nothing is written and the next cycle shows `lane_drive` = 2'b00.
- R6: A write with only one lane selected leaves the other byte of that word unchanged.
- R7: With the chip selected, `wr_n` high and `out_en_n` high, the next cycle shows `lane_drive` = 2'b00.
- R8: Any lane whose drive bit is clear reads as zero on its bits of `rdata`.
- R9: While `rst_n` is low, `lane_drive` = 2'b00, `rdata` = 0 and `standby` = 1.
- R10: `standby` is 0 in the cycle after any cycle in which `chip_sel_n` was low.
- R11: A read presented in the cycle right after a write to the same address returns the newly written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| lane_lo_n | input | 1 | Active-low select of bits 7..0 |
| lane_hi_n | input | 1 | Active-low select of bits 15..8 |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Registered read word, zero on undriven lanes |
| lane_drive | output | 2 | Registered per-lane drive flag, bit 0 for the low byte |
| standby | output | 1 | Registered deselect flag |

## Verification
The assertions assume the controls are stable and known at each rising edge. They also assume the check window starts only once one edge has passed with reset released, so a `$past` value never refers to a cycle spent in reset. The bench changes every input only at the falling edge and holds reset through several edges before releasing it on a falling edge. Reads target only bytes that were written earlier, because array contents after power-up are undefined and are not modelled.

// File: rtl/bytelane_sram_pkg.sv
package bytelane_sram_pkg;

    localparam int LANE_W  = 8;
    localparam int N_LANES = 2;
    localparam int WORD_W  = LANE_W * N_LANES;

    typedef enum logic [2:0] {
        OP_STANDBY = 3'd0,
        OP_HOLD    = 3'd1,
        OP_READ    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_NOLANE  = 3'd4
    } op_e;

endpackage

// File: rtl/bl_ctrl_decode.sv
module bl_ctrl_decode
    import bytelane_sram_pkg::*;
(
    input  logic               chip_sel_n,
    input  logic               wr_n,
    input  logic               out_en_n,
    input  logic               lane_lo_n,
    input  logic               lane_hi_n,
    output op_e                op_next,
    output logic [N_LANES-1:0] lane_act
);

    // Lane selects, active high from here on.
    always_comb begin
        lane_act    = '0;
        lane_act[0] = ~lane_lo_n;
        lane_act[1] = ~lane_hi_n;
    end

    // Priority: deselect, then no lane, then write, then read, then hold.
    always_comb begin
        if (chip_sel_n) begin
            op_next = OP_STANDBY;
        end else if (lane_lo_n && lane_hi_n) begin
            op_next = OP_NOLANE;
        end else if (!wr_n) begin
            op_next = OP_WRITE;
        end else if (!out_en_n) begin
            op_next = OP_READ;
        end else begin
            op_next = OP_HOLD;
        end
    end

endmodule

// File: rtl/bl_lane_store.sv
module bl_lane_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Array: no reset, contents undefined until written.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= wdata;
        end
    end

    // Read register: zero whenever this lane is not being read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= cells[addr];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/bl_out_stage.sv
module bl_out_stage
    import bytelane_sram_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  op_e                op_next,
    input  logic [N_LANES-1:0] lane_act,
    output op_e                op_q,
    output logic [N_LANES-1:0] lane_drive,
    output logic               standby
);

    logic [N_LANES-1:0] act_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_STANDBY;
            act_q <= '0;
        end else begin
            op_q  <= op_next;
            act_q <= lane_act;
        end
    end

    // Outputs from the held state.
    always_comb begin
        lane_drive = '0;
        standby    = 1'b0;
        unique case (op_q)
            OP_STANDBY: standby    = 1'b1;
            OP_READ:    lane_drive = act_q;
            OP_WRITE:   lane_drive = '0;
            OP_HOLD:    lane_drive = '0;
            OP_NOLANE:  lane_drive = '0;
            default:    lane_drive = '0;
        endcase
    end

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
    import bytelane_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        lane_drive,
    output logic              standby
);

    op_e                op_next;
    op_e                op_q;
    logic [N_LANES-1:0] lane_act;
    logic [WORD_W-1:0]  rd_word;

    bl_ctrl_decode u_dec (
        .chip_sel_n (chip_sel_n),
        .wr_n       (wr_n),
        .out_en_n   (out_en_n),
        .lane_lo_n  (lane_lo_n),
        .lane_hi_n  (lane_hi_n),
        .op_next    (op_next),
        .lane_act   (lane_act)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic ln_wr;
        logic ln_rd;
        assign ln_wr = (op_next == OP_WRITE) && lane_act[g];
        assign ln_rd = (op_next == OP_READ)  && lane_act[g];

        bl_lane_store #(
            .ADDR_W (ADDR_W),
            .DATA_W (LANE_W)
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ln_wr),
            .rd_en (ln_rd),
            .addr  (addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    bl_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_next    (op_next),
        .lane_act   (lane_act),
        .op_q       (op_q),
        .lane_drive (lane_drive),
        .standby    (standby)
    );

    assign rdata = rd_word;

    // Arms the checks one edge after reset is released.
    logic chk_armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_armed <= 1'b0;
        else        chk_armed <= 1'b1;
    end

    // R1
    deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(chip_sel_n)) |-> (standby && lane_drive == 2'b00));

    // R2
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!chip_sel_n && !wr_n)) |-> (lane_drive == 2'b00));

    // R3
    read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!chip_sel_n && wr_n && !out_en_n))
            |-> (lane_drive == ~$past({lane_hi_n, lane_lo_n})));

    // R5
    nolane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!chip_sel_n && lane_lo_n && lane_hi_n)) |-> (lane_drive == 2'b00));

    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!chip_sel_n && wr_n && out_en_n)) |-> (lane_drive == 2'b00));

    // R8
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lane_drive[0] |-> rdata[7:0] == 8'h00) and (!lane_drive[1] |-> rdata[15:8] == 8'h00));

    // R10
    select_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && $past(!chip_sel_n)) |-> !standby);

endmodule

// File: tb/tb_bytelane_sram.sv
module tb_bytelane_sram;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_sel_n, wr_n, out_en_n, lane_lo_n, lane_hi_n;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic [1:0]    lane_drive;
    logic          standby;

    always #2.5 clk = ~clk;

    bytelane_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_n(wr_n),
        .out_en_n(out_en_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .lane_drive(lane_drive),
        .standby(standby)
    );

    int          vecs = 0;
    int          bad  = 0;
    logic [7:0]  m_lo [int];
    logic [7:0]  m_hi [int];
    logic [1:0]  e_drv;
    logic [15:0] e_rd;
    logic        e_sb;

    task automatic check(string tag);
        vecs++;
        if (lane_drive !== e_drv || rdata !== e_rd || standby !== e_sb) begin
            bad++;
            $display("FAIL %s: drive=%b rdata=%h standby=%b, expected drive=%b rdata=%h standby=%b",
                     tag, lane_drive, rdata, standby, e_drv, e_rd, e_sb);
        end
    endtask

    // Called right after a falling edge: applies inputs, predicts, checks next cycle.
    task automatic cyc(string tag, logic cs, logic wr, logic oe, logic lo, logic hi,
                       int a, logic [15:0] d);
        chip_sel_n = cs; wr_n = wr; out_en_n = oe; lane_lo_n = lo; lane_hi_n = hi;
        addr = a[AW-1:0]; wdata = d;
        e_drv = 2'b00; e_rd = 16'h0000; e_sb = cs;
        if (!cs && !(lo && hi)) begin
            if (!wr) begin
                if (!lo) m_lo[a] = d[7:0];
                if (!hi) m_hi[a] = d[15:8];
            end else if (!oe) begin
                if (!lo) begin e_drv[0] = 1'b1; e_rd[7:0]  = m_lo[a]; end
                if (!hi) begin e_drv[1] = 1'b1; e_rd[15:8] = m_hi[a]; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        int mx;
        mx = (1 << AW) - 1;
        rst_n = 1'b0; chip_sel_n = 1'b1; wr_n = 1'b1; out_en_n = 1'b1;
        lane_lo_n = 1'b1; lane_hi_n = 1'b1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        e_drv = 2'b00; e_rd = 16'h0000; e_sb = 1'b1;
        check("R9 reset state");
        rst_n = 1'b1;

        // R2 full write with out_en low, then R11/R3 read next cycle
        cyc("R2 write oe low",      0, 0, 0, 0, 0, 5, 16'hA1B2);
        cyc("R11 read after write", 0, 1, 0, 0, 0, 5, 16'h0000);
        cyc("R4 low lane read",     0, 1, 0, 0, 1, 5, 16'h0000);
        cyc("R4 R8 high lane read", 0, 1, 0, 1, 0, 5, 16'h0000);
        // R6 partial writes
        cyc("R6 low byte write",    0, 0, 1, 0, 1, 5, 16'hFF3C);
        cyc("R6 read back",         0, 1, 0, 0, 0, 5, 16'h0000);
        cyc("R6 high byte write",   0, 0, 1, 1, 0, 5, 16'h7700);
        cyc("R6 read back",         0, 1, 0, 0, 0, 5, 16'h0000);
        // R5 write with no lanes selected
        cyc("R5 no-lane write",     0, 0, 0, 1, 1, 5, 16'hFFFF);
        cyc("R5 no-lane read",      0, 1, 0, 1, 1, 5, 16'h0000);
        cyc("R5 unchanged",         0, 1, 0, 0, 0, 5, 16'h0000);
        // R7 outputs disabled
        cyc("R7 hold",              0, 1, 1, 0, 0, 5, 16'h0000);
        // R1 deselected write attempt
        cyc("R1 deselect write",    1, 0, 0, 0, 0, 5, 16'h0000);
        cyc("R1 deselect read",     1, 1, 0, 0, 0, 5, 16'h0000);
        cyc("R10 wake",             0, 1, 1, 0, 0, 5, 16'h0000);
        cyc("R1 unchanged",         0, 1, 0, 0, 0, 5, 16'h0000);
        // Boundary addresses
        cyc("R2 top address",       0, 0, 1, 0, 0, mx, 16'h5AA5);
        cyc("R2 zero address",      0, 0, 1, 0, 0, 0,  16'hC0DE);
        cyc("R3 top address",       0, 1, 0, 0, 0, mx, 16'h0000);
        cyc("R3 zero address",      0, 1, 0, 0, 0, 0,  16'h0000);

        // Fill a window, then mixed traffic against the model
        for (int i = 0; i < 64; i++)
            cyc("R2 fill", 0, 0, 1, 0, 0, i, 16'(i * 16'h0101 ^ 16'h3C5A));
        for (int k = 0; k < 600; k++) begin
            int r;
            int sel;
            r   = int'($urandom);
            sel = r & 7;
            if (sel == 0)
                cyc("R1 mixed",  1, r[4], r[5], r[6], r[7], (r >> 8) & 63, 16'(r >> 16));
            else if (sel == 1)
                cyc("R5 mixed",  0, r[4], r[5], 1, 1, (r >> 8) & 63, 16'(r >> 16));
            else if (sel == 2)
                cyc("R7 mixed",  0, 1, 1, r[6], r[7], (r >> 8) & 63, 16'(r >> 16));
            else if (sel < 5)
                cyc("R6 mixed",  0, 0, r[5], r[6], r[6] ? 1'b0 : r[7], (r >> 8) & 63, 16'(r >> 16));
            else
                cyc("R3 mixed",  0, 1, 0, r[6], r[6] ? 1'b0 : r[7], (r >> 8) & 63, 16'h0000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule